// File: doc/BRIEF.md
# Serial NAND Page Transaction Sequencer

This block runs whole page-level jobs against a serial NAND device. It sits between a host that asks for "read this page", "program this page" or "erase this block" and a lower command engine that shifts one opcode, its address bytes, its dummy bytes and its data bytes over the serial bus. For each job the sequencer issues the right chain of single commands, watches the device's status byte and turns that byte into one result code.

A read first moves the addressed page into the device cache, then polls status until the device is idle. If the on-die ECC result is usable, it streams the requested cache bytes to the host. A program sends write enable, fills the cache with host data, starts the internal program and polls. An erase sends write enable and the block erase command, then polls. Each job has its own limit on the number of status reads. A device that stays busy past that limit ends the job with a timeout code.

Top module: `flash_page_seq`

## Requirements
- R1: A read job (reqOp=0) issues 0x13 with the 3-byte row address, then status polls, then cache read 0x03 (reqFast=0) or 0x0B (reqFast=1) with the 2-byte column address, one dummy byte and reqLen input bytes. Each cache byte appears on rdData with rdValid high.
- R2: A status poll is opcode 0x0F with the 1-byte address 0xC0 and one input byte. Polling repeats while bit 0 of that byte is 1.
- R3: When the final status of a read has bits [5:4]=0, the job ends with doneCode 0. When they are 1, it ends with doneCode 1. In both cases the job ends after the cache bytes have been delivered.
- R4: When the final status of a read has bits [5:4]=2, the job ends with doneCode 2. When they are 3 (reserved), it ends with doneCode 3. In both cases no cache read is issued.
- R5: A program job (reqOp=1) issues 0x06, then 0x02 with the 2-byte column and reqLen output bytes, then 0x10 with the 3-byte row, then polls. Each output byte is fetched with wrReq high and taken from wrData. If status bit 3 is set the job ends with doneCode 4, otherwise with 0.
- R6: An erase job (reqOp=2) issues 0x06, then 0xD8 with the 3-byte row, then polls. If status bit 2 is set the job ends with doneCode 5, otherwise with 0.
- R7: No 0x02, 0x10 or 0xD8 is issued in a job unless 0x06 was issued earlier in that job.
- R8: pollLimit is sampled when a job is accepted; a value of 0 counts as 1. If every one of those status reads reports busy, the job ends with doneCode 6 and issues nothing further.
- R9: reqReady is 1 only while no job runs. A request is taken on reqValid and reqReady. reqOp=3 is ignored: no command is issued, no doneValid is raised and reqReady stays 1.
- R10: doneValid is a single-cycle pulse, and reqReady is 1 in that cycle.
- R11: After reset reqReady=1, engStart=0 and doneValid=0.
- R12: A status bit that does not belong to the running job does not change its result. The ECC bits have no effect on program and erase, bit 3 has no effect on erase, and bit 2 has no effect on program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Job request valid |
| reqReady | output | 1 | Sequencer idle, request accepted |
| reqOp | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| reqRow | input | 24 | Row (page/block) address |
| reqCol | input | 16 | Column address in the cache |
| reqLen | input | LEN_W | Number of cache bytes moved |
| reqFast | input | 1 | Read uses the fast cache read opcode |
| pollLimit | input | POLL_W | Maximum status reads for this job |
| doneValid | output | 1 | Job finished (one cycle) |
| doneCode | output | 3 | Result code |
| engStart | output | 1 | Start one command in the engine |
| engOpcode | output | 8 | Command opcode |
| engAddr | output | 24 | Address value, low bytes used |
| engAddrBytes | output | 2 | Number of address bytes |
| engDummyBytes | output | 2 | Number of dummy bytes |
| engDir | output | 2 | Data direction: 0 none, 1 in, 2 out |
| engLen | output | LEN_W | Data byte count |
| engDone | input | 1 | Engine finished the command |
| engRxValid | input | 1 | Engine delivers an input byte |
| engRxData | input | 8 | Input byte |
| engTxReq | input | 1 | Engine takes an output byte |
| engTxData | output | 8 | Output byte |
| rdValid | output | 1 | Cache read byte valid to host |
| rdData | output | 8 | Cache read byte |
| wrReq | output | 1 | Host must present a program byte |
| wrData | input | 8 | Program byte from host |

## Verification
The hardest cases to reach from the ports are the ones that depend on how long the device stays busy. These are the timeout boundary, a limit of zero, and a failure or ECC code that only shows up in the last status byte. The bench models the command engine with a scripted device. For every job it sets how many status reads report busy and which status byte follows, so a job can end on exactly the last allowed poll or one poll early.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int ADDR_W = 24;
  localparam int COL_W  = 16;

  localparam logic [7:0] OPC_WREN      = 8'h06;
  localparam logic [7:0] OPC_LOAD      = 8'h02;
  localparam logic [7:0] OPC_EXEC      = 8'h10;
  localparam logic [7:0] OPC_ERASE     = 8'hD8;
  localparam logic [7:0] OPC_PAGE_RD   = 8'h13;
  localparam logic [7:0] OPC_CACHE_RD  = 8'h03;
  localparam logic [7:0] OPC_CACHE_FST = 8'h0B;
  localparam logic [7:0] OPC_GET_FEAT  = 8'h0F;
  localparam logic [7:0] STATUS_ADDR   = 8'hC0;

  localparam logic [1:0] DIR_NONE = 2'd0;
  localparam logic [1:0] DIR_IN   = 2'd1;
  localparam logic [1:0] DIR_OUT  = 2'd2;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_NONE = 2'd3} op_e;

  typedef enum logic [2:0] {K_WREN, K_LOAD, K_ROW, K_POLL, K_CACHE} kind_e;

  typedef enum logic [2:0] {
    RES_OK = 3'd0, RES_CORR = 3'd1, RES_UNCORR = 3'd2, RES_ECCRSV = 3'd3,
    RES_PROGFAIL = 3'd4, RES_ERASEFAIL = 3'd5, RES_TIMEOUT = 3'd6
  } res_e;

  typedef struct packed {
    logic  accept;
    logic  issue;
    kind_e kind;
    logic  dataPhase;
    logic  finish;
  } strobe_t;

  typedef struct packed {
    op_e        op;
    logic       busy;
    logic [1:0] ecc;
    logic       exhausted;
  } flags_t;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       engDone,
  input  flags_t     flags,
  output logic       reqReady,
  output strobe_t    strobe
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_EVAL} state_e;

  state_e stateQ;
  kind_e  kindQ;
  logic   readOk;

  assign readOk = (flags.op == OP_READ) && (flags.ecc < 2'd2);

  always_comb begin
    strobe           = '0;
    strobe.kind      = kindQ;
    reqReady         = 1'b0;
    case (stateQ)
      S_IDLE: begin
        reqReady      = 1'b1;
        strobe.accept = reqValid && (op_e'(reqOp) != OP_NONE);
      end
      S_ISSUE: strobe.issue = 1'b1;
      S_WAIT: begin
        strobe.dataPhase = 1'b1;
        strobe.finish    = engDone && (kindQ == K_CACHE);
      end
      S_EVAL: strobe.finish = flags.busy ? flags.exhausted : !readOk;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      kindQ  <= K_WREN;
    end else begin
      case (stateQ)
        S_IDLE: if (strobe.accept) begin
          stateQ <= S_ISSUE;
          kindQ  <= (op_e'(reqOp) == OP_READ) ? K_ROW : K_WREN;
        end
        S_ISSUE: stateQ <= S_WAIT;
        S_WAIT: if (engDone) begin
          case (kindQ)
            K_WREN: begin
              kindQ  <= (flags.op == OP_PROG) ? K_LOAD : K_ROW;
              stateQ <= S_ISSUE;
            end
            K_LOAD: begin
              kindQ  <= K_ROW;
              stateQ <= S_ISSUE;
            end
            K_ROW: begin
              kindQ  <= K_POLL;
              stateQ <= S_ISSUE;
            end
            K_POLL:  stateQ <= S_EVAL;
            default: stateQ <= S_IDLE;
          endcase
        end
        S_EVAL: begin
          if (flags.busy) begin
            stateQ <= flags.exhausted ? S_IDLE : S_ISSUE;
          end else if (readOk) begin
            kindQ  <= K_CACHE;
            stateQ <= S_ISSUE;
          end else begin
            stateQ <= S_IDLE;
          end
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  // R2: a status evaluation only ever follows a completed poll
  a_r2_eval_after_poll: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_EVAL) |-> (kindQ == K_POLL));

  // R9: nothing is started in the cycle after an idle cycle without acceptance
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE && !strobe.accept) |=> (stateQ == S_IDLE));
endmodule

// File: rtl/fseq_dpath.sv
module fseq_dpath
  import fseq_pkg::*;
#(
  parameter int LEN_W      = 13,
  parameter int POLL_W     = 16,
  parameter int SLOW_DUMMY = 1,
  parameter int FAST_DUMMY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqFast,
  input  logic [POLL_W-1:0] pollLimit,
  output flags_t            flags,
  output logic              engStart,
  output logic [7:0]        engOpcode,
  output logic [ADDR_W-1:0] engAddr,
  output logic [1:0]        engAddrBytes,
  output logic [1:0]        engDummyBytes,
  output logic [1:0]        engDir,
  output logic [LEN_W-1:0]  engLen,
  input  logic              engRxValid,
  input  logic [7:0]        engRxData,
  input  logic              engTxReq,
  output logic [7:0]        engTxData,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              wrReq,
  input  logic [7:0]        wrData,
  output logic              doneValid,
  output logic [2:0]        doneCode
);
  localparam logic [1:0] SLOW_D = 2'(SLOW_DUMMY);
  localparam logic [1:0] FAST_D = 2'(FAST_DUMMY);
  localparam logic [POLL_W-1:0] ONE_POLL = POLL_W'(1);

  op_e               opQ;
  logic [ADDR_W-1:0] rowQ;
  logic [COL_W-1:0]  colQ;
  logic [LEN_W-1:0]  lenQ;
  logic              fastQ;
  logic [POLL_W-1:0] limitQ, limitEff, pollCnt;
  logic              stBusy, stEraseFail, stProgFail;
  logic [1:0]        stEcc;
  logic              wrenSeen, rowSeen;
  res_e              resNext;
  res_e              doneCodeQ;

  assign limitEff = (limitQ == '0) ? ONE_POLL : limitQ;

  assign flags.op        = opQ;
  assign flags.busy      = stBusy;
  assign flags.ecc       = stEcc;
  assign flags.exhausted = (pollCnt >= limitEff);

  // request capture, status capture, poll counting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= OP_READ; rowQ <= '0; colQ <= '0; lenQ <= '0; fastQ <= 1'b0;
      limitQ <= '0; pollCnt <= '0;
      stBusy <= 1'b0; stEraseFail <= 1'b0; stProgFail <= 1'b0; stEcc <= 2'd0;
      wrenSeen <= 1'b0; rowSeen <= 1'b0;
    end else if (strobe.accept) begin
      opQ <= op_e'(reqOp); rowQ <= reqRow; colQ <= reqCol; lenQ <= reqLen;
      fastQ <= reqFast; limitQ <= pollLimit; pollCnt <= '0;
      stBusy <= 1'b0; stEraseFail <= 1'b0; stProgFail <= 1'b0; stEcc <= 2'd0;
      wrenSeen <= 1'b0; rowSeen <= 1'b0;
    end else begin
      if (strobe.issue && strobe.kind == K_POLL) pollCnt <= pollCnt + ONE_POLL;
      if (strobe.issue && strobe.kind == K_WREN) wrenSeen <= 1'b1;
      if (strobe.issue && strobe.kind == K_ROW)  rowSeen  <= 1'b1;
      if (strobe.dataPhase && strobe.kind == K_POLL && engRxValid) begin
        stBusy      <= engRxData[0];
        stEraseFail <= engRxData[2];
        stProgFail  <= engRxData[3];
        stEcc       <= engRxData[5:4];
      end
    end
  end

  // command field selection
  always_comb begin
    engOpcode     = OPC_WREN;
    engAddr       = '0;
    engAddrBytes  = 2'd0;
    engDummyBytes = 2'd0;
    engDir        = DIR_NONE;
    engLen        = '0;
    case (strobe.kind)
      K_LOAD: begin
        engOpcode    = OPC_LOAD;
        engAddr      = ADDR_W'(colQ);
        engAddrBytes = 2'd2;
        engDir       = DIR_OUT;
        engLen       = lenQ;
      end
      K_ROW: begin
        case (opQ)
          OP_PROG:  engOpcode = OPC_EXEC;
          OP_ERASE: engOpcode = OPC_ERASE;
          default:  engOpcode = OPC_PAGE_RD;
        endcase
        engAddr      = rowQ;
        engAddrBytes = 2'd3;
      end
      K_POLL: begin
        engOpcode    = OPC_GET_FEAT;
        engAddr      = ADDR_W'(STATUS_ADDR);
        engAddrBytes = 2'd1;
        engDir       = DIR_IN;
        engLen       = LEN_W'(1);
      end
      K_CACHE: begin
        engOpcode     = fastQ ? OPC_CACHE_FST : OPC_CACHE_RD;
        engAddr       = ADDR_W'(colQ);
        engAddrBytes  = 2'd2;
        engDummyBytes = fastQ ? FAST_D : SLOW_D;
        engDir        = DIR_IN;
        engLen        = lenQ;
      end
      default: ;
    endcase
  end

  assign engStart  = strobe.issue;
  assign engTxData = wrData;
  assign wrReq     = strobe.dataPhase && (strobe.kind == K_LOAD) && engTxReq;
  assign rdValid   = strobe.dataPhase && (strobe.kind == K_CACHE) && engRxValid;
  assign rdData    = engRxData;

  // result decode
  always_comb begin
    if (stBusy) begin
      resNext = RES_TIMEOUT;
    end else begin
      case (opQ)
        OP_PROG:  resNext = stProgFail  ? RES_PROGFAIL  : RES_OK;
        OP_ERASE: resNext = stEraseFail ? RES_ERASEFAIL : RES_OK;
        default: begin
          case (stEcc)
            2'd0:    resNext = RES_OK;
            2'd1:    resNext = RES_CORR;
            2'd2:    resNext = RES_UNCORR;
            default: resNext = RES_ECCRSV;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneCodeQ <= RES_OK;
    end else begin
      doneValid <= strobe.finish;
      if (strobe.finish) doneCodeQ <= resNext;
    end
  end
  assign doneCode = doneCodeQ;

  // R7: load, execute and erase only after write enable in this job
  a_r7_wren_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && (strobe.kind == K_LOAD || (strobe.kind == K_ROW && opQ != OP_READ)))
      |-> wrenSeen);

  // R2: polling only after the row command went out
  a_r2_poll_after_row: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.kind == K_POLL) |-> rowSeen);

  // R1, R4: cache read only when the page load finished with usable ECC
  a_r4_cache_gate: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.kind == K_CACHE) |-> (rowSeen && !stBusy && stEcc < 2'd2));

  // R8: a timeout is reported only after the full poll budget
  a_r8_timeout_budget: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneCodeQ == RES_TIMEOUT) |-> (pollCnt >= limitEff));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
  import fseq_pkg::*;
#(
  parameter int LEN_W      = 13,
  parameter int POLL_W     = 16,
  parameter int SLOW_DUMMY = 1,
  parameter int FAST_DUMMY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [23:0]       reqRow,
  input  logic [15:0]       reqCol,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqFast,
  input  logic [POLL_W-1:0] pollLimit,
  output logic              doneValid,
  output logic [2:0]        doneCode,
  output logic              engStart,
  output logic [7:0]        engOpcode,
  output logic [23:0]       engAddr,
  output logic [1:0]        engAddrBytes,
  output logic [1:0]        engDummyBytes,
  output logic [1:0]        engDir,
  output logic [LEN_W-1:0]  engLen,
  input  logic              engDone,
  input  logic              engRxValid,
  input  logic [7:0]        engRxData,
  input  logic              engTxReq,
  output logic [7:0]        engTxData,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              wrReq,
  input  logic [7:0]        wrData
);
  strobe_t strobe;
  flags_t  flags;

  fseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .engDone(engDone), .flags(flags), .reqReady(reqReady), .strobe(strobe)
  );

  fseq_dpath #(
    .LEN_W(LEN_W), .POLL_W(POLL_W), .SLOW_DUMMY(SLOW_DUMMY), .FAST_DUMMY(FAST_DUMMY)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqOp(reqOp), .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen),
    .reqFast(reqFast), .pollLimit(pollLimit), .flags(flags),
    .engStart(engStart), .engOpcode(engOpcode), .engAddr(engAddr),
    .engAddrBytes(engAddrBytes), .engDummyBytes(engDummyBytes), .engDir(engDir),
    .engLen(engLen), .engRxValid(engRxValid), .engRxData(engRxData),
    .engTxReq(engTxReq), .engTxData(engTxData), .rdValid(rdValid), .rdData(rdData),
    .wrReq(wrReq), .wrData(wrData), .doneValid(doneValid), .doneCode(doneCode)
  );
endmodule

// File: tb/flash_page_seq_bench.sv
`timescale 1ns/1ps
module flash_page_seq_bench;
  localparam int LEN_W  = 13;
  localparam int POLL_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = 2'd0;
  logic [23:0] reqRow = '0;
  logic [15:0] reqCol = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic reqFast = 1'b0;
  logic [POLL_W-1:0] pollLimit = '0;
  logic doneValid;
  logic [2:0] doneCode;
  logic engStart;
  logic [7:0] engOpcode;
  logic [23:0] engAddr;
  logic [1:0] engAddrBytes, engDummyBytes, engDir;
  logic [LEN_W-1:0] engLen;
  logic engDone = 1'b0;
  logic engRxValid = 1'b0;
  logic [7:0] engRxData = '0;
  logic engTxReq = 1'b0;
  logic [7:0] engTxData;
  logic rdValid;
  logic [7:0] rdData;
  logic wrReq;
  logic [7:0] wrData = '0;

  always #2.5 clk = ~clk;

  flash_page_seq u_flash_page_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen), .reqFast(reqFast),
    .pollLimit(pollLimit), .doneValid(doneValid), .doneCode(doneCode),
    .engStart(engStart), .engOpcode(engOpcode), .engAddr(engAddr),
    .engAddrBytes(engAddrBytes), .engDummyBytes(engDummyBytes), .engDir(engDir),
    .engLen(engLen), .engDone(engDone), .engRxValid(engRxValid), .engRxData(engRxData),
    .engTxReq(engTxReq), .engTxData(engTxData), .rdValid(rdValid), .rdData(rdData),
    .wrReq(wrReq), .wrData(wrData)
  );

  int tests = 0;
  int fails = 0;

  // command log written by the engine model
  int logN = 0;
  int logOp[64], logAddr[64], logAb[64], logDum[64], logDir[64], logLen[64];
  int busyLeft = 0;
  logic [7:0] finalStatus = 8'h00;
  int rdGood = 0, rdBad = 0, wrGood = 0, wrBad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic serveCmd();
    int n;
    logic [7:0] b;
    if (logN < 64) begin
      logOp[logN] = engOpcode; logAddr[logN] = engAddr; logAb[logN] = engAddrBytes;
      logDum[logN] = engDummyBytes; logDir[logN] = engDir; logLen[logN] = engLen;
    end
    logN++;
    n = engLen;
    @(negedge clk);
    if (engDir == 2'd1) begin
      for (int i = 0; i < n; i++) begin
        if (engOpcode == 8'h0F) begin
          if (busyLeft > 0) begin b = 8'h01; busyLeft--; end
          else b = finalStatus;
        end else begin
          b = 8'(i * 7 + 3);
        end
        engRxValid = 1'b1; engRxData = b;
        #1;
        if (engOpcode != 8'h0F) begin
          if (rdValid && rdData == b) rdGood++; else rdBad++;
        end
        @(negedge clk);
      end
    end else if (engDir == 2'd2) begin
      for (int i = 0; i < n; i++) begin
        engTxReq = 1'b1; wrData = 8'(i * 13 + 5);
        #1;
        if (wrReq && engTxData == 8'(i * 13 + 5)) wrGood++; else wrBad++;
        @(negedge clk);
      end
    end
    engRxValid = 1'b0; engTxReq = 1'b0;
    engDone = 1'b1;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  initial begin
    forever begin
      if (rstN === 1'b1 && engStart === 1'b1) serveCmd();
      else @(negedge clk);
    end
  end

  task automatic clearLog();
    logN = 0; rdGood = 0; rdBad = 0; wrGood = 0; wrBad = 0;
  endtask

  task automatic runJob(input logic [1:0] op, input logic [23:0] row, input logic [15:0] col,
                        input int len, input bit fast, input int limit,
                        output int code, output bit got);
    got = 0; code = -1;
    @(negedge clk);
    reqOp = op; reqRow = row; reqCol = col; reqLen = LEN_W'(len);
    reqFast = fast; pollLimit = POLL_W'(limit); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 3000 && !got; c++) begin
      if (doneValid) begin
        got = 1; code = doneCode;
        chk(reqReady == 1'b1, "R10 ready with done", reqReady, 1);
        @(negedge clk);
        chk(doneValid == 1'b0, "R10 done pulse", doneValid, 0);
      end else begin
        @(negedge clk);
      end
    end
    chk(got, "R9 job completes", got, 1);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R11 reqReady", reqReady, 1);
    chk(engStart == 1'b0, "R11 engStart", engStart, 0);
    chk(doneValid == 1'b0, "R11 doneValid", doneValid, 0);
  endtask

  task automatic testReadPlain();
    int code; bit got;
    clearLog(); busyLeft = 2; finalStatus = 8'h00;
    runJob(2'd0, 24'h012345, 16'h0040, 5, 0, 8, code, got);
    chk(logN == 5, "R1 read command count", logN, 5);
    chk(logOp[0] == 8'h13 && logAddr[0] == 24'h012345 && logAb[0] == 3,
        "R1 page load cmd", logOp[0], 8'h13);
    for (int k = 1; k <= 3; k++)
      chk(logOp[k] == 8'h0F && logAddr[k] == 8'hC0 && logAb[k] == 1 && logDir[k] == 1 && logLen[k] == 1,
          "R2 status poll cmd", logOp[k], 8'h0F);
    chk(logOp[4] == 8'h03 && logAddr[4] == 16'h0040 && logAb[4] == 2 && logDum[4] == 1 && logLen[4] == 5,
        "R1 cache read cmd", logOp[4], 8'h03);
    chk(rdGood == 5 && rdBad == 0, "R1 read bytes", rdGood, 5);
    chk(code == 0, "R3 clean read code", code, 0);
  endtask

  task automatic testReadFastCorrected();
    int code; bit got;
    clearLog(); busyLeft = 0; finalStatus = 8'h10;
    runJob(2'd0, 24'h000777, 16'h0003, 3, 1, 4, code, got);
    chk(logN == 3, "R1 fast read command count", logN, 3);
    chk(logOp[2] == 8'h0B && logDum[2] == 1 && logLen[2] == 3, "R1 fast cache opcode", logOp[2], 8'h0B);
    chk(rdGood == 3 && rdBad == 0, "R3 corrected read bytes", rdGood, 3);
    chk(code == 1, "R3 corrected code", code, 1);
  endtask

  task automatic testReadEccBad();
    int code; bit got;
    clearLog(); busyLeft = 1; finalStatus = 8'h20;
    runJob(2'd0, 24'h000100, 16'h0000, 4, 0, 4, code, got);
    chk(code == 2, "R4 uncorrectable code", code, 2);
    chk(logN == 3 && rdGood == 0, "R4 no cache read on uncorrectable", logN, 3);
    clearLog(); busyLeft = 0; finalStatus = 8'h30;
    runJob(2'd0, 24'h000101, 16'h0000, 4, 0, 4, code, got);
    chk(code == 3, "R4 reserved ECC code", code, 3);
    chk(logN == 2 && rdGood == 0, "R4 no cache read on reserved", logN, 2);
  endtask

  task automatic testProgram();
    int code; bit got;
    clearLog(); busyLeft = 2; finalStatus = 8'h00;
    runJob(2'd1, 24'h00ABCD, 16'h0010, 6, 0, 8, code, got);
    chk(logN == 6, "R5 program command count", logN, 6);
    chk(logOp[0] == 8'h06 && logAb[0] == 0 && logDir[0] == 0, "R7 write enable first", logOp[0], 8'h06);
    chk(logOp[1] == 8'h02 && logAddr[1] == 16'h0010 && logAb[1] == 2 && logDir[1] == 2 && logLen[1] == 6,
        "R5 load cmd", logOp[1], 8'h02);
    chk(logOp[2] == 8'h10 && logAddr[2] == 24'h00ABCD && logAb[2] == 3, "R5 execute cmd", logOp[2], 8'h10);
    chk(wrGood == 6 && wrBad == 0, "R5 program bytes", wrGood, 6);
    chk(code == 0, "R5 program ok", code, 0);
    clearLog(); busyLeft = 0; finalStatus = 8'h24;
    runJob(2'd1, 24'h00ABCE, 16'h0000, 2, 0, 8, code, got);
    chk(code == 0, "R12 program ignores ECC and erase bits", code, 0);
    clearLog(); busyLeft = 1; finalStatus = 8'h08;
    runJob(2'd1, 24'h00ABCF, 16'h0000, 2, 0, 8, code, got);
    chk(code == 4, "R5 program fail code", code, 4);
  endtask

  task automatic testErase();
    int code; bit got;
    clearLog(); busyLeft = 3; finalStatus = 8'h04;
    runJob(2'd2, 24'h004400, 16'h0000, 0, 0, 10, code, got);
    chk(logN == 6, "R6 erase command count", logN, 6);
    chk(logOp[0] == 8'h06, "R7 write enable before erase", logOp[0], 8'h06);
    chk(logOp[1] == 8'hD8 && logAddr[1] == 24'h004400 && logAb[1] == 3, "R6 erase cmd", logOp[1], 8'hD8);
    chk(code == 5, "R6 erase fail code", code, 5);
    clearLog(); busyLeft = 0; finalStatus = 8'h38;
    runJob(2'd2, 24'h004500, 16'h0000, 0, 0, 10, code, got);
    chk(code == 0, "R12 erase ignores program and ECC bits", code, 0);
  endtask

  task automatic testTimeout();
    int code; bit got;
    clearLog(); busyLeft = 3; finalStatus = 8'h00;
    runJob(2'd0, 24'h000200, 16'h0000, 2, 0, 3, code, got);
    chk(code == 6, "R8 timeout at limit", code, 6);
    chk(logN == 4, "R8 nothing after timeout", logN, 4);
    clearLog(); busyLeft = 2; finalStatus = 8'h00;
    runJob(2'd0, 24'h000201, 16'h0000, 2, 0, 3, code, got);
    chk(code == 0, "R8 idle on last allowed poll", code, 0);
    chk(logN == 5, "R8 read continues", logN, 5);
    clearLog(); busyLeft = 1; finalStatus = 8'h00;
    runJob(2'd2, 24'h000202, 16'h0000, 0, 0, 0, code, got);
    chk(code == 6, "R8 zero limit means one poll", code, 6);
    chk(logN == 3, "R8 zero limit poll count", logN, 3);
    busyLeft = 0;
  endtask

  task automatic testIgnoredOp();
    bit sawDone = 0;
    clearLog();
    @(negedge clk);
    reqOp = 2'd3; reqValid = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (doneValid) sawDone = 1;
    end
    reqValid = 1'b0;
    chk(logN == 0, "R9 op 3 issues nothing", logN, 0);
    chk(!sawDone, "R9 op 3 no done", sawDone, 0);
    chk(reqReady == 1'b1, "R9 ready after op 3", reqReady, 1);
  endtask

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadPlain();
    testReadFastCorrected();
    testReadEccBad();
    testProgram();
    testErase();
    testTimeout();
    testIgnoredOp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule